// File: doc/BRIEF.md
# Foreground Text Layer Pixel Decoder

This block turns the raster position into a foreground (text) pixel. It holds a 32 x 32 tilemap in two 1 KB banks, one for the tile code and one for the colour attribute. It fetches one row of the selected tile from an external graphics ROM and returns, for every pixel, four things: a 2-bit pixel index, an address into the colour lookup table, a transparency flag and a valid flag. It accepts a new raster position on every clock, so it can stream one pixel per cycle behind the video counters.

Each tile occupies 16 ROM bytes at 2 bits per pixel. Each byte carries four pixels. The upper nibble holds plane 0 and the lower nibble holds plane 1, and both planes use the same bit position for a given pixel. The two halves of a row are stored in swapped order: the right-hand four pixels come from the first 8 bytes of the tile and the left-hand four from the second 8 bytes. A flip input mirrors the whole layer in both axes.

Top module: `fg_text_decoder`

## Requirements
- R1: A pixel presented with `px_valid` high appears with `pix_valid` high exactly 4 clock edges later. After a synchronous reset, `pix_valid` is low.
- R2: `rom_addr` appears 2 edges after the pixel is presented and equals code*16 + row + 8 for pixel columns 0 to 3, or code*16 + row for columns 4 to 7. Here column = x mod 8 and row = y mod 8, both after any flip. The graphics ROM returns the byte on `rom_data` one edge after the address.
- R3: Bit 0 of the pixel index is taken from the upper nibble of the ROM byte and bit 1 from the lower nibble, at the same position within each nibble.
- R4: Within a nibble, column 0 or 4 (the leftmost pixel of that half-row) uses nibble bit 3, and column 3 or 7 uses nibble bit 0.
- R5: A write with `wr_addr[10]`=0 stores the tile code and a write with `wr_addr[10]`=1 stores the attribute. In both cases the entry index `wr_addr[9:0]` is tile_row*32 + tile_col, with tile_col = x/8 and tile_row = y/8 after any flip.
- R6: `clut_addr` = 512 + 8*attr[4:0] + pixel index. This selects only even 4-entry colour groups, and attribute bits 7:5 have no effect.
- R7: `pix_clear` is high exactly when the pixel index is 0.
- R8: With `flip` high, the position used for all lookups is (255-x, 255-y). This reverses both the pixel order within a row and the row order within a tile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Tilemap write strobe |
| wr_addr | input | 11 | Tilemap write address; bit 10 selects the attribute bank |
| wr_data | input | 8 | Tilemap write data |
| px_valid | input | 1 | Raster position valid |
| px_x | input | 8 | Raster X |
| px_y | input | 8 | Raster Y |
| flip | input | 1 | Mirror the layer in X and Y |
| rom_data | input | 8 | Graphics ROM byte, one cycle after rom_addr |
| rom_addr | output | 12 | Graphics ROM byte address |
| pix_valid | output | 1 | Output pixel valid |
| pix_index | output | 2 | Pixel colour index |
| clut_addr | output | 10 | Colour lookup address |
| pix_clear | output | 1 | Pixel is transparent |

## Verification
The bench sweeps every X across 64 lines, once with flip low and once with flip high. Every tile, row and column is therefore decoded against a ROM whose contents are computed from the address. A decoder that swapped the two half-rows, or that took the planes from the wrong nibbles, would return wrong indices at columns 0–3 versus 4–7 or in the two index bits. Reading the nibble bits from the wrong end would mirror the pixels inside each half-row. Attribute values with the top bits set show whether those bits leak into the lookup address or select odd groups. The flipped pass shows whether the row order inside a tile is reversed along with the columns and tile positions.

// File: rtl/fgt_pkg.sv
package fgt_pkg;
  localparam int FINE_W     = 3;   // 8 pixels per tile side
  localparam int NIB_W      = 4;   // pixels per ROM byte
  localparam int ROM_DW     = 8;
  localparam int TILE_BYTES = 16;
  localparam int PIX_W      = 2;
endpackage

// File: rtl/fg_map_bank.sv
module fg_map_bank #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/fg_addr_gen.sv
module fg_addr_gen
  import fgt_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int ATTR_W = 8,
  localparam int ROM_AW = CODE_W + 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [CODE_W-1:0] code,
  input  logic [ATTR_W-1:0] attr,
  input  logic [FINE_W-1:0] fx,
  input  logic [FINE_W-1:0] fy,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              rv,
  output logic [1:0]        rpx,
  output logic [ATTR_W-1:0] rattr
);
  // Left half-row (columns 0..3) lives in the second 8-byte half of the tile.
  always_ff @(posedge clk) begin
    if (rst) begin
      rv       <= 1'b0;
      rom_addr <= '0;
      rpx      <= '0;
      rattr    <= '0;
    end else begin
      rv       <= in_valid;
      rom_addr <= {code, ~fx[FINE_W-1], fy};
      rpx      <= fx[1:0];
      rattr    <= attr;
    end
  end

  a_r1_fetch_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> rv);
endmodule

// File: rtl/fg_pixel_sel.sv
module fg_pixel_sel
  import fgt_pkg::*;
#(
  parameter int ATTR_W     = 8,
  parameter int GROUP_BITS = 5,
  parameter int CLUT_W     = 10,
  parameter int CLUT_BASE  = 512,
  localparam int OFS_W     = GROUP_BITS + 1 + PIX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rv,
  input  logic [1:0]        rpx,
  input  logic [ATTR_W-1:0] rattr,
  input  logic [ROM_DW-1:0] rom_data,
  output logic              out_valid,
  output logic [PIX_W-1:0]  out_pix,
  output logic [CLUT_W-1:0] out_clut,
  output logic              out_clear
);
  logic              dv;
  logic [1:0]        dpx;
  logic [ATTR_W-1:0] dattr;

  // Hold position and attribute while the ROM answers.
  always_ff @(posedge clk) begin
    if (rst) begin
      dv    <= 1'b0;
      dpx   <= '0;
      dattr <= '0;
    end else begin
      dv    <= rv;
      dpx   <= rpx;
      dattr <= rattr;
    end
  end

  logic [1:0]       bsel;
  logic [PIX_W-1:0] pix_c;
  logic [OFS_W-1:0] ofs_c;

  always_comb begin
    bsel  = 2'd3 - dpx;                       // leftmost pixel = nibble MSB
    pix_c = {rom_data[{1'b0, bsel}], rom_data[{1'b1, bsel}]};
    ofs_c = {dattr[GROUP_BITS-1:0], 1'b0, pix_c};  // even groups only
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
      out_clut  <= '0;
      out_clear <= 1'b0;
    end else begin
      out_valid <= dv;
      out_pix   <= pix_c;
      out_clut  <= CLUT_W'(CLUT_BASE) + CLUT_W'(ofs_c);
      out_clear <= (pix_c == '0);
    end
  end

  a_r1_out_follows: assert property (@(posedge clk) disable iff (rst)
    dv |=> out_valid);
  a_r6_even_group: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !out_clut[PIX_W]);
  a_r6_base_window: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_clut >= CLUT_W'(CLUT_BASE)));
  a_r7_clear_zero: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_clear) |-> (out_pix == '0));
endmodule

// File: rtl/fg_text_decoder.sv
module fg_text_decoder
  import fgt_pkg::*;
#(
  parameter int COLS_LOG2 = 5,
  parameter int ROWS_LOG2 = 5,
  parameter int CODE_W    = 8,
  parameter int ATTR_W    = 8,
  parameter int CLUT_W    = 10,
  parameter int CLUT_BASE = 512,
  localparam int XW       = COLS_LOG2 + FINE_W,
  localparam int YW       = ROWS_LOG2 + FINE_W,
  localparam int MAP_AW   = COLS_LOG2 + ROWS_LOG2,
  localparam int ROM_AW   = CODE_W + 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [MAP_AW:0]   wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              px_valid,
  input  logic [XW-1:0]     px_x,
  input  logic [YW-1:0]     px_y,
  input  logic              flip,
  input  logic [ROM_DW-1:0] rom_data,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              pix_valid,
  output logic [PIX_W-1:0]  pix_index,
  output logic [CLUT_W-1:0] clut_addr,
  output logic              pix_clear
);
  logic [XW-1:0]     ex;
  logic [YW-1:0]     ey;
  logic [MAP_AW-1:0] map_raddr;

  always_comb begin
    ex        = px_x ^ {XW{flip}};
    ey        = px_y ^ {YW{flip}};
    map_raddr = {ey[YW-1:FINE_W], ex[XW-1:FINE_W]};
  end

  // Bank 0 holds tile codes, bank 1 holds attributes.
  logic [7:0] bank_q [2];
  for (genvar b = 0; b < 2; b++) begin : g_bank
    fg_map_bank #(.AW(MAP_AW), .DW(8)) u_bank (
      .clk  (clk),
      .we   (wr_en && (wr_addr[MAP_AW] == b[0])),
      .waddr(wr_addr[MAP_AW-1:0]),
      .wdata(wr_data),
      .raddr(map_raddr),
      .rdata(bank_q[b])
    );
  end

  logic              v1;
  logic [FINE_W-1:0] fx1, fy1;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1  <= 1'b0;
      fx1 <= '0;
      fy1 <= '0;
    end else begin
      v1  <= px_valid;
      fx1 <= ex[FINE_W-1:0];
      fy1 <= ey[FINE_W-1:0];
    end
  end

  logic              rv;
  logic [1:0]        rpx;
  logic [ATTR_W-1:0] rattr;

  fg_addr_gen #(.CODE_W(CODE_W), .ATTR_W(ATTR_W)) u_addr (
    .clk     (clk),
    .rst     (rst),
    .in_valid(v1),
    .code    (bank_q[0][CODE_W-1:0]),
    .attr    (bank_q[1][ATTR_W-1:0]),
    .fx      (fx1),
    .fy      (fy1),
    .rom_addr(rom_addr),
    .rv      (rv),
    .rpx     (rpx),
    .rattr   (rattr)
  );

  fg_pixel_sel #(
    .ATTR_W(ATTR_W), .GROUP_BITS(5), .CLUT_W(CLUT_W), .CLUT_BASE(CLUT_BASE)
  ) u_pix (
    .clk      (clk),
    .rst      (rst),
    .rv       (rv),
    .rpx      (rpx),
    .rattr    (rattr),
    .rom_data (rom_data),
    .out_valid(pix_valid),
    .out_pix  (pix_index),
    .out_clut (clut_addr),
    .out_clear(pix_clear)
  );

  a_r1_map_follows: assert property (@(posedge clk) disable iff (rst)
    px_valid |=> v1);
endmodule

// File: tb/sim_fg_text_decoder.sv
`timescale 1ns/1ps
module sim_fg_text_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [10:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        px_valid = 1'b0;
  logic [7:0]  px_x = '0, px_y = '0;
  logic        flip = 1'b0;
  logic [7:0]  rom_data;
  logic [11:0] rom_addr;
  logic        pix_valid, pix_clear;
  logic [1:0]  pix_index;
  logic [9:0]  clut_addr;

  always #2.5 clk = ~clk;

  fg_text_decoder u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .px_valid(px_valid), .px_x(px_x), .px_y(px_y), .flip(flip),
    .rom_data(rom_data), .rom_addr(rom_addr), .pix_valid(pix_valid),
    .pix_index(pix_index), .clut_addr(clut_addr), .pix_clear(pix_clear)
  );

  function automatic int romf(int a);
    return (a * 73 + (a >> 4) * 29 + 90) & 255;
  endfunction
  function automatic int codef(int i);
    return (i * 37 + 5) & 255;
  endfunction
  function automatic int attrf(int i);
    return (i * 11 + 3) & 255;   // upper bits vary: must not matter (R6)
  endfunction

  // synchronous ROM model: one cycle latency
  always_ff @(posedge clk) rom_data <= 8'(romf(int'(rom_addr)));

  int checks = 0, fails = 0;
  bit done = 0;
  int hv[8], hx[8], hy[8], hf[8];
  int cyc = 0;

  task automatic chk(string tag, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  function automatic int exp_addr(int x, int y, int f);
    int ex, ey, c;
    ex = f ? 255 - x : x;
    ey = f ? 255 - y : y;
    c  = codef((ey / 8) * 32 + ex / 8);
    return c * 16 + (ey % 8) + (((ex % 8) < 4) ? 8 : 0);
  endfunction

  function automatic int exp_pix(int x, int y, int f);
    int ex, d, b;
    ex = f ? 255 - x : x;
    d  = romf(exp_addr(x, y, f));
    b  = 3 - (ex % 4);
    return (((d >> b) & 1) << 1) | ((d >> (4 + b)) & 1);
  endfunction

  task automatic step(int v, int x, int y, int f);
    int s;
    @(negedge clk);
    // rom address of the pixel driven two negedges ago (R2)
    s = (cyc - 2) & 7;
    if (cyc >= 2 && hv[s] != 0)
      chk(hf[s] != 0 ? "R2/R8" : "R2/R5", "rom_addr",
          int'(rom_addr), exp_addr(hx[s], hy[s], hf[s]));
    // output of the pixel driven four negedges ago (R1,R3,R4,R5,R6,R7,R8)
    s = (cyc - 4) & 7;
    if (cyc >= 4) begin
      chk("R1", "pix_valid", int'(pix_valid), hv[s]);
      if (hv[s] != 0) begin
        int p, ex, ey;
        p  = exp_pix(hx[s], hy[s], hf[s]);
        ex = hf[s] != 0 ? 255 - hx[s] : hx[s];
        ey = hf[s] != 0 ? 255 - hy[s] : hy[s];
        chk(hf[s] != 0 ? "R8" : "R3/R4", "pix_index", int'(pix_index), p);
        chk("R6", "clut_addr", int'(clut_addr),
            512 + 8 * (attrf((ey / 8) * 32 + ex / 8) & 31) + p);
        chk("R7", "pix_clear", int'(pix_clear), (p == 0) ? 1 : 0);
      end
    end
    px_valid = (v != 0);
    px_x = 8'(x); px_y = 8'(y); flip = (f != 0);
    s = cyc & 7;
    hv[s] = v; hx[s] = x; hy[s] = y; hf[s] = f;
    cyc++;
  endtask

  initial begin
    for (int i = 0; i < 8; i++) hv[i] = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "pix_valid after reset", int'(pix_valid), 0);
    // load tilemap: codes in low bank, attributes in high bank (R5)
    for (int i = 0; i < 1024; i++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 11'(i); wr_data = 8'(codef(i));
      @(negedge clk);
      wr_addr = 11'(1024 + i); wr_data = 8'(attrf(i));
    end
    @(negedge clk);
    wr_en = 1'b0;
    for (int f = 0; f < 2; f++)
      for (int y = 0; y < 64; y++)
        for (int x = 0; x < 256; x++)
          step(1, x, (f != 0) ? 255 - y : y, f);
    // gaps in the stream: valid must drop (R1)
    step(0, 0, 0, 0);
    step(1, 13, 200, 0);
    step(0, 0, 0, 0);
    step(1, 250, 9, 1);
    for (int i = 0; i < 6; i++) step(0, 0, 0, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule